// File: doc/BRIEF.md
# Multiplexed DRAM access sequencer

This block sits between a microprocessor-style memory bus and a 64K-byte array made of four 16K-bit DRAM banks. When a read, opcode-fetch or write strobe arrives for an enabled address, it latches the bus address. It drives the low seven address bits to the shared DRAM address pins as the row and strobes RAS for the one bank named by the two top address bits. It then switches the pins to the next seven bits as the column and strobes CAS. RAS and CAS are released together. The sequencer then waits for the strobe to drop before it accepts another access.

Refresh is driven by the processor. The processor raises a refresh request and places a row number on the low address bits. The sequencer resynchronises the request to its own clock and turns each rising edge into one RAS-only cycle on all four banks, using that row. A configurable window can switch off one or both of the top two 8K regions. Accesses there get no RAS, no CAS and no read-data drive. The read-data bus driver is enabled only for reads and opcode fetches.

Top module: `dram_seq`

## Requirements
- R1: While reset is low, and after it is released with no request, all four RAS lines and CAS are high, the write enable is high and the read-data enable is low.
- R2: During an access the DRAM address pins carry bus_addr[6:0] while only RAS is low, and bus_addr[13:7] from the column phase to the end of CAS.
- R3: With strobe seen at a clock edge, RAS is low from that edge for ROW_HOLD cycles with the row on the pins. One cycle follows with the column on the pins and CAS still high. CAS is then low for CAS_W cycles.
- R4: During an access only ras_n[bus_addr[15:14]] is low.
- R5: RAS and CAS return high on the same edge after the CAS phase. No further access starts until every strobe has been low for at least one cycle.
- R6: A refresh cycle drives all four RAS lines low for RFSH_W cycles, keeps CAS high, and puts on the pins the bus_addr[6:0] value sampled when the request edge was detected.
- R7: The refresh request passes two synchroniser stages and an edge detector. Refresh RAS first appears in the fourth clock cycle after the request rises, and a request held high produces only one refresh cycle.
- R8: A strobe that arrives during a refresh cycle waits. The access starts after the refresh ends, with one cycle of all-high RAS between them.
- R9: For a read (rd_req) or opcode fetch (fetch_req), dout_en is high from the first CAS cycle until the strobe is dropped. For a write (wr_req), we_n is low from the first RAS cycle to the last CAS cycle and dout_en stays low.
- R10: win_sel selects the enabled space. 0 enables all of 0000h-FFFFh. 1 enables 0000h-DFFFh. 2 enables 0000h-BFFFh plus E000h-FFFFh. 3 enables 0000h-BFFFh.
- R11: A strobe to a disabled address produces no RAS, no CAS, no we_n and no dout_en for as long as it is held.
- R12: A refresh request that rises during an access does not disturb it. The refresh cycle runs right after the sequencer returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Bus address; low 7 bits carry the refresh row during refresh |
| rd_req | input | 1 | Memory read strobe, level, held until the cycle completes |
| fetch_req | input | 1 | Opcode-fetch strobe, treated as a read |
| wr_req | input | 1 | Memory write strobe |
| rfsh_req | input | 1 | Refresh request from the processor, asynchronous, active high |
| win_sel | input | 2 | Address window option (see R10) |
| dram_addr | output | 7 | Multiplexed row/column address to the DRAM chips |
| ras_n | output | 4 | Per-bank row address strobe, active low |
| cas_n | output | 1 | Column address strobe shared by all banks, active low |
| we_n | output | 1 | DRAM write enable and write-data buffer enable, active low |
| dout_en | output | 1 | Enable for the tri-state read-data bus driver |

## Verification
On every cycle, the embedded properties check these points. CAS never falls without some RAS already low. CAS never appears with all banks in refresh. At most one bank is strobed outside refresh. RAS and CAS rise together. The column address holds still under CAS. Read drive and write enable never overlap. The exact cycle counts of each phase are shown only by the bench scenarios, which replay them against a timeline computed from the parameters. So are the bank and row/column values, the four window options, the resynchroniser latency and the ordering of a strobe or a refresh that arrives during the other kind of cycle.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ROW  = 3'd1,
        ST_MUX  = 3'd2,
        ST_CAS  = 3'd3,
        ST_HOLD = 3'd4,
        ST_REF  = 3'd5
    } seq_state_t;

    typedef enum logic [1:0] {
        WIN_ALL      = 2'd0,
        WIN_NO_TOP8  = 2'd1,
        WIN_NO_MID8  = 2'd2,
        WIN_NO_TOP16 = 2'd3
    } win_mode_t;

endpackage

// File: rtl/dram_rfsh_sync.sv
module dram_rfsh_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rfsh_async,
    output logic rise_o
);
    // sh[0..STAGES-1] synchroniser chain, sh[STAGES] previous synced value
    logic [STAGES:0] sh_d, sh_q;

    assign sh_d[0] = rfsh_async;

    genvar g;
    generate
        for (g = 1; g <= STAGES; g++) begin : g_chain
            assign sh_d[g] = sh_q[g-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/dram_win_dec.sv
module dram_win_dec
    import dram_seq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        win_sel,
    output logic              hit
);
    localparam int TERM_BIT = ADDR_W - 3;

    logic in_top;
    logic term;

    assign in_top = &addr[ADDR_W-1 -: 2];

    always_comb begin
        unique case (win_mode_t'(win_sel))
            WIN_ALL:      term = 1'b0;
            WIN_NO_TOP8:  term = addr[TERM_BIT];
            WIN_NO_MID8:  term = ~addr[TERM_BIT];
            default:      term = 1'b1;
        endcase
    end

    assign hit = ~(in_top & term);

endmodule

// File: rtl/dram_timing_fsm.sv
module dram_timing_fsm
    import dram_seq_pkg::*;
#(
    parameter int MA_W     = 7,
    parameter int BANK_W   = 2,
    parameter int ROW_HOLD = 2,
    parameter int CAS_W    = 3,
    parameter int RFSH_W   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [BANK_W+2*MA_W-1:0] bus_addr,
    input  logic                     rd_req,
    input  logic                     fetch_req,
    input  logic                     wr_req,
    input  logic                     rfsh_rise,
    input  logic                     hit,
    output logic [MA_W-1:0]          dram_addr,
    output logic [(1<<BANK_W)-1:0]   ras_n,
    output logic                     cas_n,
    output logic                     we_n,
    output logic                     dout_en
);
    localparam int ADDR_W = BANK_W + 2*MA_W;
    localparam int NBANK  = 1 << BANK_W;
    localparam int MAX_A  = (ROW_HOLD > CAS_W) ? ROW_HOLD : CAS_W;
    localparam int MAXC   = (MAX_A > RFSH_W) ? MAX_A : RFSH_W;
    localparam int CNT_W  = $clog2(MAXC + 1);

    typedef struct packed {
        seq_state_t        st;
        logic [CNT_W-1:0]  cnt;
        logic [BANK_W-1:0] bank;
        logic [MA_W-1:0]   row;
        logic [MA_W-1:0]   col;
        logic              is_wr;
        logic              pend;
        logic [MA_W-1:0]   rfrow;
    } seq_regs_t;

    seq_regs_t cur_q, nxt_d;
    logic      any_req;

    assign any_req = rd_req | fetch_req | wr_req;

    always_comb begin
        nxt_d = cur_q;
        if (rfsh_rise) begin
            nxt_d.pend  = 1'b1;
            nxt_d.rfrow = bus_addr[MA_W-1:0];
        end
        unique case (cur_q.st)
            ST_IDLE: begin
                if (cur_q.pend) begin
                    nxt_d.st   = ST_REF;
                    nxt_d.cnt  = '0;
                    nxt_d.row  = cur_q.rfrow;
                    nxt_d.pend = rfsh_rise;
                end else if (any_req && hit) begin
                    nxt_d.st    = ST_ROW;
                    nxt_d.cnt   = '0;
                    nxt_d.bank  = bus_addr[ADDR_W-1 -: BANK_W];
                    nxt_d.row   = bus_addr[MA_W-1:0];
                    nxt_d.col   = bus_addr[2*MA_W-1:MA_W];
                    nxt_d.is_wr = wr_req & ~rd_req & ~fetch_req;
                end
            end
            ST_ROW: begin
                if (cur_q.cnt == CNT_W'(ROW_HOLD - 1)) begin
                    nxt_d.st  = ST_MUX;
                    nxt_d.cnt = '0;
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end
            ST_MUX: begin
                nxt_d.st  = ST_CAS;
                nxt_d.cnt = '0;
            end
            ST_CAS: begin
                if (cur_q.cnt == CNT_W'(CAS_W - 1)) begin
                    nxt_d.st  = ST_HOLD;
                    nxt_d.cnt = '0;
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end
            ST_HOLD: begin
                if (!any_req) nxt_d.st = ST_IDLE;
            end
            ST_REF: begin
                if (cur_q.cnt == CNT_W'(RFSH_W - 1)) begin
                    nxt_d.st  = ST_IDLE;
                    nxt_d.cnt = '0;
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q    <= '0;
            cur_q.st <= ST_IDLE;
        end else begin
            cur_q <= nxt_d;
        end
    end

    // Moore outputs decoded from registered state
    logic in_access;
    logic col_phase;

    assign in_access = (cur_q.st == ST_ROW) || (cur_q.st == ST_MUX) || (cur_q.st == ST_CAS);
    assign col_phase = (cur_q.st == ST_MUX) || (cur_q.st == ST_CAS);

    always_comb begin
        ras_n = '1;
        if (cur_q.st == ST_REF) begin
            ras_n = '0;
        end else if (in_access) begin
            for (int b = 0; b < NBANK; b++) begin
                if (cur_q.bank == BANK_W'(b)) ras_n[b] = 1'b0;
            end
        end
    end

    assign cas_n     = ~(cur_q.st == ST_CAS);
    assign dram_addr = col_phase ? cur_q.col : cur_q.row;
    assign we_n      = ~(cur_q.is_wr & in_access);
    assign dout_en   = ~cur_q.is_wr & ((cur_q.st == ST_CAS) || (cur_q.st == ST_HOLD));

    // CAS only ever falls under an open row (R3)
    p_cas_under_ras_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> (ras_n != '1));

    // RAS precedes CAS by at least one cycle (R3)
    p_ras_before_cas_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> ($past(ras_n) != '1));

    // all-bank strobe is refresh, never with CAS (R6)
    p_ref_no_cas_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n == '0) |-> cas_n);

    // outside refresh at most one bank strobed (R4)
    p_bank_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n != '0) |-> $onehot0(~ras_n));

    // RAS and CAS released on the same edge (R5)
    p_release_together_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_n) |-> (ras_n == '1));

    // column address stable while CAS is held (R2)
    p_col_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n && !$rose(cas_n)) |-> $stable(dram_addr));

    // read drive and write enable never overlap (R9)
    p_rd_wr_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> we_n);

endmodule

// File: rtl/dram_seq.sv
module dram_seq #(
    parameter int MA_W        = 7,
    parameter int BANKS       = 4,
    parameter int ROW_HOLD    = 2,
    parameter int CAS_W       = 3,
    parameter int RFSH_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [$clog2(BANKS)+2*MA_W-1:0] bus_addr,
    input  logic                            rd_req,
    input  logic                            fetch_req,
    input  logic                            wr_req,
    input  logic                            rfsh_req,
    input  logic [1:0]                      win_sel,
    output logic [MA_W-1:0]                 dram_addr,
    output logic [BANKS-1:0]                ras_n,
    output logic                            cas_n,
    output logic                            we_n,
    output logic                            dout_en
);
    localparam int BANK_W = $clog2(BANKS);
    localparam int ADDR_W = BANK_W + 2*MA_W;

    logic rfsh_rise;
    logic win_hit;

    dram_rfsh_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .rfsh_async (rfsh_req),
        .rise_o     (rfsh_rise)
    );

    dram_win_dec #(
        .ADDR_W (ADDR_W)
    ) u_win (
        .addr    (bus_addr),
        .win_sel (win_sel),
        .hit     (win_hit)
    );

    dram_timing_fsm #(
        .MA_W     (MA_W),
        .BANK_W   (BANK_W),
        .ROW_HOLD (ROW_HOLD),
        .CAS_W    (CAS_W),
        .RFSH_W   (RFSH_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .rd_req    (rd_req),
        .fetch_req (fetch_req),
        .wr_req    (wr_req),
        .rfsh_rise (rfsh_rise),
        .hit       (win_hit),
        .dram_addr (dram_addr),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .dout_en   (dout_en)
    );

endmodule

// File: tb/dram_seq_tb.sv
module dram_seq_tb;
    localparam int RH = 2;
    localparam int CW = 3;
    localparam int RW = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        rd_req = 1'b0, fetch_req = 1'b0, wr_req = 1'b0, rfsh_req = 1'b0;
    logic [1:0]  win_sel = 2'd0;
    logic [6:0]  dram_addr;
    logic [3:0]  ras_n;
    logic        cas_n, we_n, dout_en;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    dram_seq #(.ROW_HOLD(RH), .CAS_W(CW), .RFSH_W(RW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .rd_req(rd_req),
        .fetch_req(fetch_req), .wr_req(wr_req), .rfsh_req(rfsh_req),
        .win_sel(win_sel), .dram_addr(dram_addr), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .dout_en(dout_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic nstep();
        @(negedge clk);
    endtask

    function automatic logic [3:0] bank_mask(input logic [15:0] a);
        return ~(4'b0001 << a[15:14]);
    endfunction

    // kind: 0 read, 1 opcode fetch, 2 write
    task automatic run_access(input logic [15:0] a, input int kind);
        int last_cas;
        bit wr;
        wr = (kind == 2);
        last_cas = RH + 1 + CW;
        bus_addr  = a;
        rd_req    = (kind == 0);
        fetch_req = (kind == 1);
        wr_req    = wr;
        for (int i = 1; i <= last_cas + 1; i++) begin
            nstep();
            chk("R4 bank RAS", ras_n, (i <= last_cas) ? bank_mask(a) : 4'hF);
            chk("R3 CAS timing", cas_n, (i >= RH + 2 && i <= last_cas) ? 1'b0 : 1'b1);
            if (i <= RH)
                chk("R2 row address", dram_addr, a[6:0]);
            else if (i <= last_cas)
                chk("R2 column address", dram_addr, a[13:7]);
            chk("R9 we_n", we_n, (wr && i <= last_cas) ? 1'b0 : 1'b1);
            chk("R9 dout_en", dout_en, (!wr && i >= RH + 2) ? 1'b1 : 1'b0);
        end
        // held strobe: still idle outputs, no second access (R5)
        nstep();
        chk("R5 no re-trigger while held", ras_n, 4'hF);
        rd_req = 1'b0; fetch_req = 1'b0; wr_req = 1'b0;
        nstep();
        chk("R5 release idle RAS", ras_n, 4'hF);
        chk("R9 dout_en off after strobe", dout_en, 1'b0);
    endtask

    task automatic run_refresh(input logic [6:0] row);
        bus_addr = {9'h0A5, row};
        rfsh_req = 1'b1;
        for (int i = 1; i <= RW + 5; i++) begin
            nstep();
            if (i <= 3) begin
                chk("R7 sync latency", ras_n, 4'hF);
            end else if (i <= 3 + RW) begin
                chk("R6 refresh all RAS", ras_n, 4'h0);
                chk("R6 refresh no CAS", cas_n, 1'b1);
                chk("R6 refresh row", dram_addr, row);
            end else begin
                chk("R7 one refresh per edge", ras_n, 4'hF);
            end
        end
        rfsh_req = 1'b0;
        repeat (4) nstep();
    endtask

    task automatic try_window(input logic [1:0] mode, input logic [15:0] a);
        bit term, hit;
        case (mode)
            2'd0: term = 1'b0;
            2'd1: term = a[13];
            2'd2: term = ~a[13];
            default: term = 1'b1;
        endcase
        hit = !(a[15] && a[14] && term);
        win_sel = mode;
        bus_addr = a;
        rd_req = 1'b1;
        nstep();
        chk("R10 window decode", ras_n, hit ? bank_mask(a) : 4'hF);
        if (hit) begin
            repeat (RH + CW + 1) nstep();
        end else begin
            for (int i = 0; i < 4; i++) begin
                nstep();
                chk("R11 disabled RAS", ras_n, 4'hF);
                chk("R11 disabled CAS", cas_n, 1'b1);
                chk("R11 disabled dout_en", dout_en, 1'b0);
                chk("R11 disabled we_n", we_n, 1'b1);
            end
        end
        rd_req = 1'b0;
        repeat (2) nstep();
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1 reset state
        repeat (3) nstep();
        chk("R1 reset RAS", ras_n, 4'hF);
        chk("R1 reset CAS", cas_n, 1'b1);
        chk("R1 reset we_n", we_n, 1'b1);
        chk("R1 reset dout_en", dout_en, 1'b0);
        rst_n = 1'b1;
        repeat (3) nstep();
        chk("R1 idle after reset", {ras_n, cas_n, we_n, dout_en}, {4'hF, 1'b1, 1'b1, 1'b0});

        // R2 R3 R4 R9 accesses on each bank and each kind
        run_access(16'h1234, 0);
        run_access(16'h5A81, 1);
        run_access(16'hA7F3, 2);
        run_access(16'hFFFF, 0);
        run_access(16'h0000, 2);

        // R6 R7 refresh
        run_refresh(7'h55);
        run_refresh(7'h7F);

        // R8 strobe during refresh waits
        bus_addr = 16'h0033;
        rfsh_req = 1'b1;
        for (int i = 1; i <= 8; i++) begin
            nstep();
            if (i == 5) begin
                bus_addr = 16'h6789;
                rd_req = 1'b1;
                chk("R8 refresh in progress", ras_n, 4'h0);
            end
            if (i == 6) chk("R8 refresh not cut short", ras_n, 4'h0);
            if (i == 7) chk("R8 idle gap", ras_n, 4'hF);
            if (i == 8) begin
                chk("R8 access after refresh", ras_n, bank_mask(16'h6789));
                chk("R8 access row", dram_addr, 7'h09);
            end
        end
        repeat (RH + CW + 1) nstep();
        rd_req = 1'b0;
        rfsh_req = 1'b0;
        repeat (4) nstep();

        // R12 refresh during access deferred
        bus_addr = 16'h4321;
        wr_req = 1'b1;
        for (int i = 1; i <= RH + CW + 2; i++) begin
            nstep();
            if (i == 1) rfsh_req = 1'b1;
            if (i == RH + 2) begin
                chk("R12 access undisturbed RAS", ras_n, bank_mask(16'h4321));
                chk("R12 access undisturbed CAS", cas_n, 1'b0);
            end
        end
        chk("R12 held access idle", ras_n, 4'hF);
        wr_req = 1'b0;
        nstep();
        chk("R12 idle before refresh", ras_n, 4'hF);
        nstep();
        chk("R12 deferred refresh", ras_n, 4'h0);
        chk("R12 deferred refresh row", dram_addr, 7'h21);
        repeat (RW + 2) nstep();
        rfsh_req = 1'b0;
        repeat (4) nstep();

        // R10 R11 window options
        for (int m = 0; m < 4; m++) begin
            try_window(2'(m), 16'h1234);
            try_window(2'(m), 16'hC123);
            try_window(2'(m), 16'hE456);
        end

        finish_run();
    end

endmodule